// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits beside a CPU core and decides which exception the core services next. It gathers a configurable number of maskable I-class requests, one X-class maskable request, a combined software-interrupt/debug request, an illegal-opcode trap and three reset causes. It arbitrates among them in a single fixed descending vector map, and it tells the core through a registered flag that an interrupt is waiting. When the core strobes a vector fetch, the block latches the 16-bit vector address of the winner and holds it for the whole two-byte read.

The core's I and X mask bits gate the two maskable classes. So do two separate inhibit inputs. A writable promotion register lifts any one I source above all other I sources. A force register, live only in test mode, drives I request lines from inside the block. In stop or wait mode a wake output is raised for any serviceable interrupt, and also for a raw X request that is currently masked.

Top module: `ivec_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) int_pending and wake read 0, and vec_addr reads 0xFFFE.
- R2: I source k (bit k of i_req) has vector 0xFF00 + 2*k. Among the serviceable I sources, the one with the highest k wins, unless R3 applies.
- R3: A write of prio_data through prio_we stores a promotion byte, with reset value 0xF2. If the byte is even and byte/2 < NUM_I, source byte/2 outranks every other I source while it is serviceable. Any other byte leaves the natural order of R2 unchanged. The new byte affects arbitration from the cycle after the write.
- R4: x_req has vector 0xFFF4 and beats every I source. It is serviceable only while both x_mask and x_block are 0.
- R5: trap_req (vector 0xFFF8) and swi_req (vector 0xFFF6) ignore every mask and inhibit input. trap beats swi, and both beat X and I.
- R6: rst_ext_req (0xFFFE) beats rst_clkmon_req (0xFFFC), which beats rst_wdog_req (0xFFFA). Every reset cause beats all other requests at a vector fetch. Reset causes do not set int_pending.
- R7: An I source is serviceable only while both i_mask and i_block are 0.
- R8: int_pending is a register. Its value after a clock edge is 1 exactly when trap, swi, a serviceable X or a serviceable I source was present before that edge.
- R9: vec_addr loads the winning vector at an edge where vec_fetch is 1 and some request (resets included) is present. At every other edge it keeps its value, whatever the requests do.
- R10: wake is a register. After an edge it is 1 exactly when low_power was 1 and either the R8 pending condition held or x_req was 1, even with x_mask or x_block set.
- R11: While test_mode is 1, force_we loads force_data into a force register. While test_mode is 1, the bits of that register act as extra I requests from the next cycle on. While test_mode is 0, writes are ignored and the forced bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_req | input | NUM_I | I-class request lines |
| x_req | input | 1 | X-class request |
| swi_req | input | 1 | Software interrupt / debug request |
| trap_req | input | 1 | Illegal-opcode trap |
| rst_ext_req | input | 1 | External/power reset cause |
| rst_clkmon_req | input | 1 | Clock monitor reset cause |
| rst_wdog_req | input | 1 | Watchdog reset cause |
| i_mask | input | 1 | CPU I mask bit |
| x_mask | input | 1 | CPU X mask bit |
| i_block | input | 1 | Inhibit for I servicing |
| x_block | input | 1 | Inhibit for X servicing |
| low_power | input | 1 | CPU in stop or wait mode |
| test_mode | input | 1 | Special test mode |
| force_we | input | 1 | Force register write strobe |
| force_data | input | NUM_I | Force register write data |
| prio_we | input | 1 | Promotion register write strobe |
| prio_data | input | 8 | Promotion byte (I vector low byte) |
| vec_fetch | input | 1 | Vector fetch strobe from the CPU |
| int_pending | output | 1 | Interrupt waiting for service |
| vec_addr | output | 16 | Captured vector address |
| wake | output | 1 | Wake request for stop/wait |

## Verification
The hardest case to reach is a promotion byte that is written one cycle and must take effect only on the next. In the same window the force register has to inject I requests while test mode and a competing real request are both live. The stimulus writes the promotion byte and the force register in one step, then fetches in the following steps while the real request lines toggle. The bench model updates its own copies of the two registers only after it has predicted the current cycle, so a design that applies a write one cycle early disagrees with it. A randomized sweep then mixes fetch strobes, masks, inhibits and low-power mode to check that the captured vector holds while requests come and go.

// File: rtl/ivc_pkg.sv
// Package: shared vector constants and the arbitration candidate type
// for the prioritized interrupt vector controller.
package ivc_pkg;
    localparam logic [15:0] VEC_RST_EXT    = 16'hFFFE;
    localparam logic [15:0] VEC_RST_CLKMON = 16'hFFFC;
    localparam logic [15:0] VEC_RST_WDOG   = 16'hFFFA;
    localparam logic [15:0] VEC_TRAP       = 16'hFFF8;
    localparam logic [15:0] VEC_SWI        = 16'hFFF6;
    localparam logic [15:0] VEC_X          = 16'hFFF4;
    localparam logic [7:0]  I_BASE_HI      = 8'hFF;
    localparam logic [7:0]  PRIO_RESET     = 8'hF2;
    localparam int          IDX_W          = 7;

    typedef struct packed {
        logic        valid;
        logic [15:0] vec;
    } ivc_cand_t;
endpackage

// File: rtl/ivc_cfg_regs.sv
// Module: ivc_cfg_regs
// Holds the promotion byte and the test force register.
// Assumes: the force register is writable and effective only in test mode.
module ivc_cfg_regs #(
    parameter int NUM_I = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_mode,
    input  logic             force_we,
    input  logic [NUM_I-1:0] force_data,
    input  logic             prio_we,
    input  logic [7:0]       prio_data,
    output logic [NUM_I-1:0] force_act,
    output logic [7:0]       prio_q
);
    import ivc_pkg::*;

    logic [NUM_I-1:0] force_q;

    // Promotion byte register, written through prio_we.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio_q <= PRIO_RESET;
        else if (prio_we) prio_q <= prio_data;
    end

    // Force register, written only while test mode is active.
    always_ff @(posedge clk) begin
        if (!rst_n)                      force_q <= '0;
        else if (force_we && test_mode)  force_q <= force_data;
    end

    // Forced lines reach the arbiter only in test mode.
    always_comb force_act = test_mode ? force_q : '0;

    AST_FORCE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> $stable(force_q)); // R11
endmodule

// File: rtl/ivc_i_arb.sv
// Module: ivc_i_arb
// Picks one serviceable I source: promoted source first, otherwise the
// highest index. Produces the vector 0xFF00 + 2*index.
// Assumes: req_eff is already masked; NUM_I is 2..122.
module ivc_i_arb #(
    parameter int NUM_I = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_I-1:0] req_eff,
    input  logic [7:0]       prio_q,
    output logic             valid,
    output logic [15:0]      vec
);
    import ivc_pkg::*;

    logic [NUM_I-1:0] grant_nat;
    logic [NUM_I-1:0] promo_hot;
    logic [NUM_I-1:0] grant;
    logic             promo_ok;
    logic [IDX_W-1:0] idx;

    // Natural order: a source wins when no higher index is requesting.
    for (genvar k = 0; k < NUM_I; k++) begin : g_nat
        if (k == NUM_I - 1) begin : g_top
            assign grant_nat[k] = req_eff[k];
        end else begin : g_low
            assign grant_nat[k] = req_eff[k] & ~(|req_eff[NUM_I-1:k+1]);
        end
        assign promo_hot[k] = promo_ok && (prio_q[7:1] == IDX_W'(k));
    end

    // Promotion is valid for an even byte that names an existing source.
    always_comb promo_ok = !prio_q[0] && (prio_q[7:1] < IDX_W'(NUM_I));

    // Promoted source overrides natural order when it is requesting.
    always_comb grant = (|(promo_hot & req_eff)) ? (promo_hot & req_eff) : grant_nat;

    // Encode the granted index.
    always_comb begin
        idx = '0;
        for (int k = 0; k < NUM_I; k++) if (grant[k]) idx = IDX_W'(k);
    end

    // Form the vector from the index.
    always_comb begin
        valid = |req_eff;
        vec   = {I_BASE_HI, idx, 1'b0};
    end

    AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2
    AST_GRANT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_eff) == '0); // R2
    AST_PROMO_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(promo_hot & req_eff)) |-> (grant == (promo_hot & req_eff))); // R3
endmodule

// File: rtl/ivc_resolve.sv
// Module: ivc_resolve
// Final fixed-priority selection across reset, trap, SWI, X and I.
// Assumes: X and I inputs are already qualified by masks and inhibits.
module ivc_resolve (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rst_ext_req,
    input  logic                rst_clkmon_req,
    input  logic                rst_wdog_req,
    input  logic                trap_req,
    input  logic                swi_req,
    input  logic                x_svc,
    input  ivc_pkg::ivc_cand_t  i_cand,
    output ivc_pkg::ivc_cand_t  win,
    output logic                svc_pend
);
    import ivc_pkg::*;

    // Descending vector order picks the winner.
    always_comb begin
        win.valid = 1'b1;
        if (rst_ext_req)         win.vec = VEC_RST_EXT;
        else if (rst_clkmon_req) win.vec = VEC_RST_CLKMON;
        else if (rst_wdog_req)   win.vec = VEC_RST_WDOG;
        else if (trap_req)       win.vec = VEC_TRAP;
        else if (swi_req)        win.vec = VEC_SWI;
        else if (x_svc)          win.vec = VEC_X;
        else begin
            win.valid = i_cand.valid;
            win.vec   = i_cand.vec;
        end
    end

    // Interrupt (non-reset) request present.
    always_comb svc_pend = trap_req | swi_req | x_svc | i_cand.valid;

    AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_ext_req || rst_clkmon_req || rst_wdog_req) |-> (win.vec[15:3] == 13'h1FFF && win.vec[2:1] != 2'b00)); // R6
endmodule

// File: rtl/ivec_ctrl.sv
// Module: ivec_ctrl (top)
// Prioritized interrupt vector controller: masks requests, arbitrates,
// registers the pending flag and wake, and latches the vector on fetch.
// Assumes: vec_fetch is a one-cycle strobe; request inputs are synchronous.
module ivec_ctrl #(
    parameter int NUM_I = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_I-1:0] i_req,
    input  logic             x_req,
    input  logic             swi_req,
    input  logic             trap_req,
    input  logic             rst_ext_req,
    input  logic             rst_clkmon_req,
    input  logic             rst_wdog_req,
    input  logic             i_mask,
    input  logic             x_mask,
    input  logic             i_block,
    input  logic             x_block,
    input  logic             low_power,
    input  logic             test_mode,
    input  logic             force_we,
    input  logic [NUM_I-1:0] force_data,
    input  logic             prio_we,
    input  logic [7:0]       prio_data,
    input  logic             vec_fetch,
    output logic             int_pending,
    output logic [15:0]      vec_addr,
    output logic             wake
);
    import ivc_pkg::*;

    logic [NUM_I-1:0] force_act;
    logic [7:0]       prio_q;
    logic [NUM_I-1:0] i_eff;
    logic             x_svc;
    logic             i_valid;
    logic [15:0]      i_vec;
    ivc_cand_t        i_cand;
    ivc_cand_t        win;
    logic             svc_pend;

    ivc_cfg_regs #(.NUM_I(NUM_I)) u_cfg (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .force_we(force_we), .force_data(force_data),
        .prio_we(prio_we), .prio_data(prio_data),
        .force_act(force_act), .prio_q(prio_q)
    );

    // Qualify I and X requests with the mask bits and inhibits.
    always_comb begin
        i_eff = (i_req | force_act) & {NUM_I{!(i_mask || i_block)}};
        x_svc = x_req && !x_mask && !x_block;
    end

    ivc_i_arb #(.NUM_I(NUM_I)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_eff(i_eff), .prio_q(prio_q),
        .valid(i_valid), .vec(i_vec)
    );

    // Pack the I candidate.
    always_comb begin
        i_cand.valid = i_valid;
        i_cand.vec   = i_vec;
    end

    ivc_resolve u_res (
        .clk(clk), .rst_n(rst_n),
        .rst_ext_req(rst_ext_req), .rst_clkmon_req(rst_clkmon_req),
        .rst_wdog_req(rst_wdog_req), .trap_req(trap_req), .swi_req(swi_req),
        .x_svc(x_svc), .i_cand(i_cand), .win(win), .svc_pend(svc_pend)
    );

    // Registered pending flag and wake request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pending <= 1'b0;
            wake        <= 1'b0;
        end else begin
            int_pending <= svc_pend;
            wake        <= low_power && (svc_pend || x_req);
        end
    end

    // Vector latch, loaded only on a fetch strobe with a winner.
    always_ff @(posedge clk) begin
        if (!rst_n)                       vec_addr <= VEC_RST_EXT;
        else if (vec_fetch && win.valid)  vec_addr <= win.vec;
    end

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_fetch |=> $stable(vec_addr)); // R9
    AST_EXT_RESET_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && rst_ext_req) |=> (vec_addr == 16'hFFFE)); // R6
    AST_AWAKE_ONLY_LP: assert property (@(posedge clk) disable iff (!rst_n)
        !low_power |=> !wake); // R10
    AST_X_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (low_power && x_req) |=> wake); // R10
    AST_TRAP_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> int_pending); // R5
endmodule

// File: tb/ivec_ctrl_test.sv
// Scoreboard bench: the driver predicts each cycle from a model of the
// requirements and queues it; the monitor compares after the clock edge.
module ivec_ctrl_test;
    localparam int NUM_I = 8;

    typedef struct {
        logic        pend;
        logic [15:0] vec;
        logic        wake;
        string       tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic [NUM_I-1:0] i_req = '0;
    logic x_req = 0, swi_req = 0, trap_req = 0;
    logic rst_ext_req = 0, rst_clkmon_req = 0, rst_wdog_req = 0;
    logic i_mask = 0, x_mask = 0, i_block = 0, x_block = 0;
    logic low_power = 0, test_mode = 0, force_we = 0, prio_we = 0, vec_fetch = 0;
    logic [NUM_I-1:0] force_data = '0;
    logic [7:0] prio_data = '0;
    logic int_pending, wake;
    logic [15:0] vec_addr;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t q[$];

    logic [NUM_I-1:0] m_force = '0;
    logic [7:0]       m_prio  = 8'hF2;
    logic [15:0]      m_vec   = 16'hFFFE;

    ivec_ctrl #(.NUM_I(NUM_I)) uut (
        .clk(clk), .rst_n(rst_n), .i_req(i_req), .x_req(x_req),
        .swi_req(swi_req), .trap_req(trap_req), .rst_ext_req(rst_ext_req),
        .rst_clkmon_req(rst_clkmon_req), .rst_wdog_req(rst_wdog_req),
        .i_mask(i_mask), .x_mask(x_mask), .i_block(i_block), .x_block(x_block),
        .low_power(low_power), .test_mode(test_mode), .force_we(force_we),
        .force_data(force_data), .prio_we(prio_we), .prio_data(prio_data),
        .vec_fetch(vec_fetch), .int_pending(int_pending), .vec_addr(vec_addr),
        .wake(wake)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: model the current inputs, queue the prediction, advance one cycle.
    task automatic step(input string tag);
        exp_t e;
        logic [NUM_I-1:0] ie;
        logic ival, xs, pc;
        logic [15:0] iv, wv;
        int pidx;
        ie = (i_req | (test_mode ? m_force : '0)) & {NUM_I{!(i_mask || i_block)}};
        ival = |ie;
        iv = 16'hFF00;
        for (int k = 0; k < NUM_I; k++) if (ie[k]) iv = 16'hFF00 + 16'(2 * k);
        pidx = int'(m_prio[7:1]);
        if (!m_prio[0] && pidx < NUM_I && ie[pidx]) iv = 16'hFF00 + 16'(2 * pidx);
        xs = x_req && !x_mask && !x_block;
        pc = trap_req || swi_req || xs || ival;
        if (rst_ext_req)         wv = 16'hFFFE;
        else if (rst_clkmon_req) wv = 16'hFFFC;
        else if (rst_wdog_req)   wv = 16'hFFFA;
        else if (trap_req)       wv = 16'hFFF8;
        else if (swi_req)        wv = 16'hFFF6;
        else if (xs)             wv = 16'hFFF4;
        else                     wv = iv;
        if (vec_fetch && (pc || rst_ext_req || rst_clkmon_req || rst_wdog_req)) m_vec = wv;
        e.pend = pc;
        e.vec  = m_vec;
        e.wake = low_power && (pc || x_req);
        e.tag  = tag;
        q.push_back(e);
        if (prio_we) m_prio = prio_data;
        if (force_we && test_mode) m_force = force_data;
        @(negedge clk);
        vec_fetch = 0;
        prio_we = 0;
        force_we = 0;
    endtask

    // Monitor: pop one prediction per edge and compare.
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            check({e.tag, " pending"}, {15'd0, int_pending}, {15'd0, e.pend});
            check({e.tag, " vector"}, vec_addr, e.vec);
            check({e.tag, " wake"}, {15'd0, wake}, {15'd0, e.wake});
        end
    end

    task automatic clear_reqs();
        i_req = '0; x_req = 0; swi_req = 0; trap_req = 0;
        rst_ext_req = 0; rst_clkmon_req = 0; rst_wdog_req = 0;
        i_mask = 0; x_mask = 0; i_block = 0; x_block = 0; low_power = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1 pending", {15'd0, int_pending}, 16'd0);
        check("R1 vector", vec_addr, 16'hFFFE);
        check("R1 wake", {15'd0, wake}, 16'd0);

        // R2: natural I order
        i_req = 8'b0010_0110; vec_fetch = 1; step("R2 highest");
        i_req = 8'b0000_0001; vec_fetch = 1; step("R2 source0");
        i_req = 8'b1000_0000; vec_fetch = 1; step("R2 source7");
        // R9: hold while requests change
        i_req = 8'b0000_0010; step("R9 hold");
        i_req = '0; vec_fetch = 1; step("R9 empty fetch");
        // R7: masks and inhibits
        i_req = 8'hFF; i_mask = 1; vec_fetch = 1; step("R7 imask");
        i_mask = 0; i_block = 1; vec_fetch = 1; step("R7 iblock");
        i_block = 0; step("R8 pending");
        // R3: promotion, takes effect next cycle
        i_req = 8'b1000_1000; prio_we = 1; prio_data = 8'h06; vec_fetch = 1; step("R3 write cycle");
        vec_fetch = 1; step("R3 promoted");
        i_req = 8'b1000_0000; vec_fetch = 1; step("R3 promo idle");
        i_req = 8'b1000_1000; prio_we = 1; prio_data = 8'h07; step("R3 odd write");
        vec_fetch = 1; step("R3 odd byte");
        prio_we = 1; prio_data = 8'h20; step("R3 range write");
        vec_fetch = 1; step("R3 out of range");
        // R4: X
        x_req = 1; vec_fetch = 1; step("R4 x wins");
        x_mask = 1; vec_fetch = 1; step("R4 x masked");
        x_mask = 0; x_block = 1; vec_fetch = 1; step("R4 x blocked");
        x_block = 0;
        // R5: trap and swi
        swi_req = 1; i_mask = 1; x_mask = 1; vec_fetch = 1; step("R5 swi");
        trap_req = 1; vec_fetch = 1; step("R5 trap");
        // R6: resets
        rst_wdog_req = 1; vec_fetch = 1; step("R6 wdog");
        rst_clkmon_req = 1; vec_fetch = 1; step("R6 clkmon");
        rst_ext_req = 1; vec_fetch = 1; step("R6 ext");
        clear_reqs();
        rst_clkmon_req = 1; vec_fetch = 1; step("R6 alone no pending");
        clear_reqs();
        // R10: wake
        low_power = 1; x_req = 1; x_mask = 1; step("R10 masked x wakes");
        x_req = 0; step("R10 idle sleep");
        i_req = 8'h04; step("R10 i wakes");
        i_mask = 1; step("R10 masked i");
        low_power = 0; i_mask = 0; step("R10 awake");
        clear_reqs();
        // R11: force register
        force_we = 1; force_data = 8'h40; step("R11 locked write");
        test_mode = 1; vec_fetch = 1; step("R11 nothing forced");
        force_we = 1; force_data = 8'h40; i_req = 8'h01; vec_fetch = 1; step("R11 write cycle");
        vec_fetch = 1; step("R11 forced");
        test_mode = 0; vec_fetch = 1; step("R11 force off");
        i_req = '0; step("R11 idle");

        // R8/R9: randomized sweep
        for (int n = 0; n < 400; n++) begin
            i_req = NUM_I'($urandom);
            x_req = $urandom_range(0, 3) == 0;
            swi_req = $urandom_range(0, 7) == 0;
            trap_req = $urandom_range(0, 9) == 0;
            rst_wdog_req = $urandom_range(0, 15) == 0;
            i_mask = $urandom_range(0, 2) == 0;
            i_block = $urandom_range(0, 4) == 0;
            x_mask = $urandom_range(0, 2) == 0;
            x_block = $urandom_range(0, 4) == 0;
            low_power = $urandom_range(0, 1) == 1;
            test_mode = $urandom_range(0, 1) == 1;
            force_we = $urandom_range(0, 5) == 0;
            force_data = NUM_I'($urandom);
            prio_we = $urandom_range(0, 7) == 0;
            prio_data = 8'($urandom_range(0, 20));
            vec_fetch = $urandom_range(0, 1) == 1;
            step("R8 R9 sweep");
        end
        clear_reqs();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule